// File: doc/BRIEF.md
# Two-Level Instruction Control Decoder

This block is the purely combinational control unit of a single-cycle 32-bit processor. Each cycle it looks at two fields of the current instruction word: the 6-bit major opcode (word bits 31 to 26) and the 6-bit function field (word bits 5 to 0). From them it drives every control point of the surrounding datapath. These are the register-file write enable, the destination-register select, the second-operand select, the data-memory read and write enables, the write-back source select, the branch and jump qualifiers, and a 3-bit ALU operation code.

Decoding is split into two levels. A main decoder turns the opcode into the datapath controls and a 2-bit ALU class. A second decoder maps that class, together with the function field, onto the ALU operation code. Memory-access instructions always get an add. Branch-if-equal always gets a subtract. Register-register instructions take their operation from the function field.

The datapath is not part of this block. That includes the register file, the ALU, the memories and the next-PC logic. The block has no clock and no state.

Top module: `instr_ctrl_unit`

## Requirements
- R1: For load word (opcode 0x23) and store word (opcode 0x2B), the ALU code is 010 (add). For branch-if-equal (opcode 0x04), the ALU code is 110 (subtract).
- R2: For a register-register instruction (opcode 0x00), funct bits 3..0 select the ALU code as follows: 0000 gives 010 (add), 0010 gives 110 (subtract), 0100 gives 000 (and), 0101 gives 001 (or), 1010 gives 111 (set-less-than). Funct bits 5..4 have no effect.
- R3: For opcode 0x00 with any other funct bits 3..0 value, the ALU code is 000 and the register write enable stays 1.
- R4: The register write enable is 1 for opcodes 0x00 and 0x23. It is 0 for opcodes 0x2B, 0x04 and 0x02 (jump).
- R5: The destination select is 1 (rd) only for opcode 0x00. For every other opcode it is 0 (rt).
- R6: The operand select is 0 (second register) for opcodes 0x00 and 0x04. It is 1 (sign-extended immediate) for every other opcode.
- R7: Memory read and write-back-from-memory are 1 only for opcode 0x23. Memory write is 1 only for opcode 0x2B.
- R8: Branch is 1 only for opcode 0x04. Jump is 1 only for opcode 0x02.
- R9: Any opcode other than 0x00, 0x23, 0x2B, 0x04 and 0x02 drives register write, destination select, memory read, memory write, write-back-from-memory, branch and jump all to 0. Such an opcode gets the ALU code 010.
- R10: For any opcode other than 0x00, the funct field has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Major opcode, instruction bits 31..26 |
| funct_i | input | 6 | Function field, instruction bits 5..0 |
| reg_write_o | output | 1 | Register file write enable |
| reg_dst_o | output | 1 | Destination select: 1 = rd, 0 = rt |
| alu_src_o | output | 1 | Second ALU operand: 1 = immediate, 0 = register |
| mem_read_o | output | 1 | Data memory read enable |
| mem_write_o | output | 1 | Data memory write enable |
| mem_to_reg_o | output | 1 | Write-back source: 1 = memory, 0 = ALU |
| branch_o | output | 1 | Conditional branch qualifier |
| jump_o | output | 1 | Jump target select |
| alu_ctl_o | output | 3 | ALU operation code |

## Verification
The bench sweeps all 64 opcodes against a set of funct values. It also sweeps all 64 funct values under the register-register opcode.

This exposes the following faults:
- A decoder that also examines funct bits 5..4 would break the alias pairs, for example 0x20 versus 0x00.
- A decoder that lets funct leak into memory or branch instructions would give a load something other than an add.
- A decoder that defaults an unknown funct to add, or clears the write enable for it, would be caught on the unlisted funct codes.
- Opcodes outside the recognised set are checked for any write or control-transfer enable left high, because one left high would corrupt state on an illegal instruction.

// File: rtl/ctrl_pkg.sv
// Package: shared encodings for the two-level instruction control decoder.
// Assumes the 6-bit major opcode and 6-bit function field layout of a
// 32-bit three-register / immediate instruction format.
package ctrl_pkg;

    localparam int OP_W    = 6;
    localparam int FUNCT_W = 6;
    localparam int ALUC_W  = 3;
    localparam int FSEL_W  = 4;  // funct bits actually examined

    localparam logic [OP_W-1:0] OPC_RREG  = 6'h00;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'h02;

    // ALU class handed from the first to the second decoding level
    typedef enum logic [1:0] {
        ACLS_ADD  = 2'b00,
        ACLS_SUB  = 2'b01,
        ACLS_FUNC = 2'b10,
        ACLS_RSVD = 2'b11
    } alu_cls_e;

    // ALU operation codes seen by the datapath
    typedef enum logic [ALUC_W-1:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    // funct low-nibble selectors for register-register operations
    localparam logic [FSEL_W-1:0] FN_ADD = 4'b0000;
    localparam logic [FSEL_W-1:0] FN_SUB = 4'b0010;
    localparam logic [FSEL_W-1:0] FN_AND = 4'b0100;
    localparam logic [FSEL_W-1:0] FN_OR  = 4'b0101;
    localparam logic [FSEL_W-1:0] FN_SLT = 4'b1010;

    // Datapath control bundle produced by the main decoder
    typedef struct packed {
        logic reg_write;
        logic reg_dst;
        logic alu_src;
        logic mem_read;
        logic mem_write;
        logic mem_to_reg;
        logic branch;
        logic jump;
    } dp_ctl_t;

    localparam dp_ctl_t DP_NOP = '{
        reg_write: 1'b0, reg_dst: 1'b0, alu_src: 1'b1, mem_read: 1'b0,
        mem_write: 1'b0, mem_to_reg: 1'b0, branch: 1'b0, jump: 1'b0};

endpackage

// File: rtl/ctrl_main_dec.sv
// Module: first decoding level. Maps the major opcode onto the datapath
// control bundle and a 2-bit ALU class. Assumes nothing about funct.
// An unrecognised opcode yields the inert bundle (no writes, no transfer).
module ctrl_main_dec
    import ctrl_pkg::*;
(
    input  logic [OP_W-1:0] opcode_i,
    output dp_ctl_t         ctl_o,
    output alu_cls_e        cls_o
);

    // Opcode to control bundle and ALU class
    always_comb begin
        ctl_o = DP_NOP;
        cls_o = ACLS_ADD;
        unique case (opcode_i)
            OPC_RREG: begin
                ctl_o.reg_write = 1'b1;
                ctl_o.reg_dst   = 1'b1;
                ctl_o.alu_src   = 1'b0;
                cls_o           = ACLS_FUNC;
            end
            OPC_LOAD: begin
                ctl_o.reg_write  = 1'b1;
                ctl_o.mem_read   = 1'b1;
                ctl_o.mem_to_reg = 1'b1;
            end
            OPC_STORE: begin
                ctl_o.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctl_o.alu_src = 1'b0;
                ctl_o.branch  = 1'b1;
                cls_o         = ACLS_SUB;
            end
            OPC_JUMP: begin
                ctl_o.jump = 1'b1;
            end
            default: begin
                ctl_o = DP_NOP;
                cls_o = ACLS_ADD;
            end
        endcase
    end

endmodule

// File: rtl/ctrl_alu_dec.sv
// Module: second decoding level. Combines the ALU class with the low funct
// bits to form the ALU operation code. Assumes the upper funct bits were
// already stripped by the caller. An unlisted funct gives the AND code.
module ctrl_alu_dec
    import ctrl_pkg::*;
(
    input  alu_cls_e          cls_i,
    input  logic [FSEL_W-1:0] fsel_i,
    output alu_op_e           op_o
);

    alu_op_e fn_op;

    // funct nibble to operation for register-register instructions
    always_comb begin
        unique case (fsel_i)
            FN_ADD:  fn_op = ALU_ADD;
            FN_SUB:  fn_op = ALU_SUB;
            FN_AND:  fn_op = ALU_AND;
            FN_OR:   fn_op = ALU_OR;
            FN_SLT:  fn_op = ALU_SLT;
            default: fn_op = ALU_AND;
        endcase
    end

    // Class selects forced add, forced subtract, or funct-driven operation
    always_comb begin
        unique case (cls_i)
            ACLS_ADD:  op_o = ALU_ADD;
            ACLS_SUB:  op_o = ALU_SUB;
            ACLS_FUNC: op_o = fn_op;
            ACLS_RSVD: op_o = fn_op;
            default:   op_o = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/instr_ctrl_unit.sv
// Module: top of the two-level control decoder for a single-cycle core.
// Purely combinational; the datapath samples its outputs within the same
// cycle the instruction word is presented. No clock, no state.
module instr_ctrl_unit
    import ctrl_pkg::*;
(
    input  logic [OP_W-1:0]    opcode_i,
    input  logic [FUNCT_W-1:0] funct_i,
    output logic               reg_write_o,
    output logic               reg_dst_o,
    output logic               alu_src_o,
    output logic               mem_read_o,
    output logic               mem_write_o,
    output logic               mem_to_reg_o,
    output logic               branch_o,
    output logic               jump_o,
    output logic [ALUC_W-1:0]  alu_ctl_o
);

    dp_ctl_t  dp_ctl;
    alu_cls_e alu_cls;
    alu_op_e  alu_op;
    logic     unused_fhi;

    // Upper funct bits do not participate in decoding
    assign unused_fhi = ^funct_i[FUNCT_W-1:FSEL_W];

    ctrl_main_dec u_main (
        .opcode_i (opcode_i),
        .ctl_o    (dp_ctl),
        .cls_o    (alu_cls)
    );

    ctrl_alu_dec u_alu (
        .cls_i  (alu_cls),
        .fsel_i (funct_i[FSEL_W-1:0]),
        .op_o   (alu_op)
    );

    // Fan the control bundle out to individual ports
    always_comb begin
        reg_write_o  = dp_ctl.reg_write;
        reg_dst_o    = dp_ctl.reg_dst;
        alu_src_o    = dp_ctl.alu_src;
        mem_read_o   = dp_ctl.mem_read;
        mem_write_o  = dp_ctl.mem_write;
        mem_to_reg_o = dp_ctl.mem_to_reg;
        branch_o     = dp_ctl.branch;
        jump_o       = dp_ctl.jump;
        alu_ctl_o    = alu_op;
    end

endmodule

// File: rtl/instr_ctrl_unit_chk.sv
// Module: assertion checker for instr_ctrl_unit, attached by bind. Uses
// immediate assertions because the block has no clock.
module instr_ctrl_unit_chk
    import ctrl_pkg::*;
(
    input logic [OP_W-1:0]   opcode_i,
    input logic              reg_write_o,
    input logic              reg_dst_o,
    input logic              alu_src_o,
    input logic              mem_read_o,
    input logic              mem_write_o,
    input logic              mem_to_reg_o,
    input logic              branch_o,
    input logic              jump_o,
    input logic [ALUC_W-1:0] alu_ctl_o,
    input logic [1:0]        alu_cls
);

    logic known_op;

    // Recognised-opcode flag, formed independently of the main decoder
    assign known_op = (opcode_i == OPC_RREG) || (opcode_i == OPC_LOAD) ||
                      (opcode_i == OPC_STORE) || (opcode_i == OPC_BEQ) ||
                      (opcode_i == OPC_JUMP);

    // Immediate checks on every settled input change
    always_comb begin
        // R7
        mem_excl_chk: assert (!(mem_read_o && mem_write_o))
            else $error("memory read and write together");
        // R8
        xfer_excl_chk: assert (!(branch_o && jump_o))
            else $error("branch and jump together");
        // R5
        rdst_rtype_chk: assert (!reg_dst_o || (reg_write_o && !alu_src_o))
            else $error("rd select without register-register controls");
        // R1
        sub_class_chk: assert (alu_cls != 2'b01 || alu_ctl_o == 3'b110)
            else $error("subtract class did not give subtract");
        // R9
        unknown_inert_chk: assert (known_op || !(reg_write_o || mem_read_o ||
                               mem_write_o || mem_to_reg_o || branch_o || jump_o))
            else $error("unrecognised opcode raised an enable");
        // R3
        rreg_writes_chk: assert (opcode_i != OPC_RREG || reg_write_o)
            else $error("register-register opcode without write enable");
    end

endmodule

bind instr_ctrl_unit instr_ctrl_unit_chk u_chk (
    .opcode_i     (opcode_i),
    .reg_write_o  (reg_write_o),
    .reg_dst_o    (reg_dst_o),
    .alu_src_o    (alu_src_o),
    .mem_read_o   (mem_read_o),
    .mem_write_o  (mem_write_o),
    .mem_to_reg_o (mem_to_reg_o),
    .branch_o     (branch_o),
    .jump_o       (jump_o),
    .alu_ctl_o    (alu_ctl_o),
    .alu_cls      (alu_cls)
);

// File: tb/sim_instr_ctrl_unit.sv
`timescale 1ns/1ps
// Bench: drives opcode/funct once per clock and compares every output with
// a behavioural reference computed from the requirements.
module sim_instr_ctrl_unit;

    logic       clk = 1'b0;
    logic [5:0] opcode;
    logic [5:0] funct;
    logic       rw, rd, asrc, mrd, mwr, m2r, br, jp;
    logic [2:0] actl;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;  // 250 MHz

    instr_ctrl_unit u0 (
        .opcode_i (opcode), .funct_i (funct),
        .reg_write_o (rw), .reg_dst_o (rd), .alu_src_o (asrc),
        .mem_read_o (mrd), .mem_write_o (mwr), .mem_to_reg_o (m2r),
        .branch_o (br), .jump_o (jp), .alu_ctl_o (actl)
    );

    task automatic chk(input string tag, input string sig, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s op=%02h fn=%02h got=%0d exp=%0d", tag, sig, opcode, funct, got, exp);
        end
    endtask

    // Behavioural reference: expected outputs straight from the requirements
    task automatic apply(input logic [5:0] op, input logic [5:0] fn);
        bit e_rw, e_rd, e_as, e_mr, e_mw, e_m2, e_br, e_jp;
        int e_alu;
        string t_ctl, t_alu;
        @(negedge clk);
        opcode = op;
        funct  = fn;
        e_rw = 0; e_rd = 0; e_as = 1; e_mr = 0; e_mw = 0; e_m2 = 0; e_br = 0; e_jp = 0;
        e_alu = 2; t_ctl = "R9"; t_alu = "R9";
        if (op == 6'h00) begin
            e_rw = 1; e_rd = 1; e_as = 0; t_ctl = "R5";
            case (fn & 6'h0F)
                6'h00: begin e_alu = 2; t_alu = "R2"; end
                6'h02: begin e_alu = 6; t_alu = "R2"; end
                6'h04: begin e_alu = 0; t_alu = "R2"; end
                6'h05: begin e_alu = 1; t_alu = "R2"; end
                6'h0A: begin e_alu = 7; t_alu = "R2"; end
                default: begin e_alu = 0; t_alu = "R3"; t_ctl = "R3"; end
            endcase
        end else if (op == 6'h23) begin
            e_rw = 1; e_mr = 1; e_m2 = 1; t_ctl = "R7"; t_alu = (fn != 0) ? "R10" : "R1";
        end else if (op == 6'h2B) begin
            e_mw = 1; t_ctl = "R7"; t_alu = (fn != 0) ? "R10" : "R1";
        end else if (op == 6'h04) begin
            e_as = 0; e_br = 1; e_alu = 6; t_ctl = "R8"; t_alu = (fn != 0) ? "R10" : "R1";
        end else if (op == 6'h02) begin
            e_jp = 1; t_ctl = "R8"; t_alu = "R10";
        end
        @(posedge clk);
        #1;
        chk((t_ctl == "R9") ? "R9" : "R4", "reg_write", rw, e_rw);
        chk((t_ctl == "R9") ? "R9" : "R5", "reg_dst", rd, e_rd);
        chk((t_ctl == "R9") ? "R9" : "R6", "alu_src", asrc, e_as);
        chk(t_ctl, "mem_read", mrd, e_mr);
        chk(t_ctl, "mem_write", mwr, e_mw);
        chk(t_ctl, "mem_to_reg", m2r, e_m2);
        chk(t_ctl, "branch", br, e_br);
        chk(t_ctl, "jump", jp, e_jp);
        chk(t_alu, "alu_ctl", actl, e_alu);
    endtask

    initial begin
        opcode = 6'h00;
        funct  = 6'h00;
        // Initial pattern: register-register add
        apply(6'h00, 6'h00);
        // R2: named funct codes and their upper-bit aliases
        apply(6'h00, 6'h20); apply(6'h00, 6'h22); apply(6'h00, 6'h24);
        apply(6'h00, 6'h25); apply(6'h00, 6'h2A); apply(6'h00, 6'h1A);
        // R1 R4 R6 R7 R8: each recognised non-register opcode
        apply(6'h23, 6'h00); apply(6'h2B, 6'h00); apply(6'h04, 6'h00); apply(6'h02, 6'h00);
        // R3: every funct under the register-register opcode
        for (int f = 0; f < 64; f++) apply(6'h00, 6'(f));
        // R9 R10: every opcode against several funct values
        for (int o = 0; o < 64; o++) begin
            apply(6'(o), 6'h22); apply(6'(o), 6'h25);
            apply(6'(o), 6'h2A); apply(6'(o), 6'h3F);
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired got=0 exp=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule